// File: doc/BRIEF.md
# Combinational Unsigned Divider with Status Flags

This block divides one unsigned operand by another in pure combinational logic and returns a quotient and a remainder of the same width as the operands. It is the divide path of an 8-bit-class accumulator ALU. The operand width is a parameter, and the outputs settle within one propagation delay of any input change. No clock or state is involved.

Next to the arithmetic result the block produces the flag set of the divide instruction. The carry output is a vector with one bit per started nibble of the operand width. Its top bit is the main carry and is always cleared. The lower bits are auxiliary carries that pass straight through. The overflow output is raised only when the divisor is zero.

The incoming main carry and overflow bits are accepted but have no effect on any output. On a zero divisor the quotient is driven to all ones and the remainder returns the dividend, so that downstream logic sees a fixed value.

Top module: `comb_divider`

## Requirements
- R1: With a nonzero divisor, `quotientOut` equals the dividend divided by the divisor, rounded toward zero (unsigned).
- R2: With a nonzero divisor, `remainderOut` equals the dividend modulo the divisor, and it is always smaller than the divisor.
- R3: Bit CWIDTH-1 of `carryOut` is 0 for every input combination, where CWIDTH = (DWIDTH-1)/4+1.
- R4: With a nonzero divisor, `overflowOut` is 0.
- R5: With a divisor of zero, `overflowOut` is 1.
- R6: With a divisor of zero, `quotientOut` is all ones and `remainderOut` equals `dividendIn`.
- R7: Bits CWIDTH-2 down to 0 of `carryOut` equal the same bits of `carryIn`.
- R8: `overflowIn` and bit CWIDTH-1 of `carryIn` have no effect on `quotientOut`, `remainderOut`, `overflowOut` or `carryOut`.
- R9: The outputs reflect new inputs within the same clock period, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividendIn | input | DWIDTH | Unsigned dividend |
| divisorIn | input | DWIDTH | Unsigned divisor |
| carryIn | input | CWIDTH | Incoming carry vector; top bit is the main carry, lower bits are auxiliary carries |
| overflowIn | input | 1 | Incoming overflow flag (ignored) |
| quotientOut | output | DWIDTH | Quotient, or all ones on a zero divisor |
| remainderOut | output | DWIDTH | Remainder, or the dividend on a zero divisor |
| carryOut | output | CWIDTH | Outgoing carry vector: top bit cleared, lower bits passed through |
| overflowOut | output | 1 | Set on a zero divisor, cleared otherwise |

## Verification
The zero-divisor detection and the array's quotient and remainder generation act on the same inputs and resolve in the same settling interval. A wrong override mux would let the raw array value leak through, or would let the flag disagree with the data. The bench provokes this by holding a dividend and flipping the divisor between zero and nonzero values, including the extremes 1 and all ones. It repeats this under every combination of incoming carry and overflow bits. Each result is judged against quotient, remainder and flag values that the bench computes with integer arithmetic. A full sweep of all operand pairs at the default width covers the rest.

// File: rtl/comb_divider_pkg.sv
package comb_divider_pkg;

  // Strobes from the divide control to the datapath output stage
  typedef struct packed {
    logic zeroDivisor;
    logic forceQuotOnes;
    logic passRemainder;
  } divStrobes_t;

endpackage

// File: rtl/div_stage.sv
// One restoring step: shift in a dividend bit, try to subtract, keep or restore.
module div_stage #(
  parameter int DWIDTH = 8
) (
  input  logic [DWIDTH-1:0] remIn,
  input  logic              dividendBit,
  input  logic [DWIDTH-1:0] divisor,
  output logic [DWIDTH-1:0] remOut,
  output logic              quotBit
);
  logic [DWIDTH:0] partial;
  logic [DWIDTH:0] diff;
  logic            borrow;

  assign partial = {remIn, dividendBit};
  assign diff    = partial - {1'b0, divisor};
  // partial < 2*divisor holds for a nonzero divisor, so the top bit is the borrow
  assign borrow  = diff[DWIDTH];
  assign quotBit = ~borrow;
  assign remOut  = borrow ? partial[DWIDTH-1:0] : diff[DWIDTH-1:0];
endmodule

// File: rtl/div_datapath.sv
// Restoring array divider plus the output override stage.
module div_datapath
  import comb_divider_pkg::*;
#(
  parameter int DWIDTH = 8
) (
  input  logic [DWIDTH-1:0] dividendIn,
  input  logic [DWIDTH-1:0] divisorIn,
  input  divStrobes_t       strobes,
  output logic [DWIDTH-1:0] quotientOut,
  output logic [DWIDTH-1:0] remainderOut
);
  logic [DWIDTH-1:0] quotRaw;
  logic [DWIDTH-1:0] remRaw;

  for (genvar k = 0; k < DWIDTH; k++) begin : stg
    logic [DWIDTH-1:0] remPrev;
    logic [DWIDTH-1:0] remNext;
    logic              qBit;

    if (k == 0) begin : g_first
      assign remPrev = '0;
    end else begin : g_rest
      assign remPrev = stg[k-1].remNext;
    end

    div_stage #(.DWIDTH(DWIDTH)) u_stage (
      .remIn      (remPrev),
      .dividendBit(dividendIn[DWIDTH-1-k]),
      .divisor    (divisorIn),
      .remOut     (remNext),
      .quotBit    (qBit)
    );

    assign quotRaw[DWIDTH-1-k] = qBit;
  end

  assign remRaw = stg[DWIDTH-1].remNext;

  assign quotientOut  = strobes.forceQuotOnes ? '1 : quotRaw;
  assign remainderOut = strobes.passRemainder ? dividendIn : remRaw;
endmodule

// File: rtl/div_ctrl.sv
// Divide control: zero-divisor detection and flag generation.
module div_ctrl
  import comb_divider_pkg::*;
#(
  parameter int DWIDTH = 8,
  parameter int CWIDTH = (DWIDTH - 1) / 4 + 1
) (
  input  logic [DWIDTH-1:0] divisorIn,
  input  logic [CWIDTH-1:0] carryIn,
  output divStrobes_t       strobes,
  output logic [CWIDTH-1:0] carryOut,
  output logic              overflowOut
);
  logic isZero;

  assign isZero = (divisorIn == '0);

  always_comb begin
    strobes               = '0;
    strobes.zeroDivisor   = isZero;
    strobes.forceQuotOnes = isZero;
    strobes.passRemainder = isZero;
  end

  assign overflowOut = strobes.zeroDivisor;

  if (CWIDTH > 1) begin : g_aux
    assign carryOut = {1'b0, carryIn[CWIDTH-2:0]};
  end else begin : g_noaux
    assign carryOut = 1'b0;
  end
endmodule

// File: rtl/comb_divider.sv
module comb_divider
  import comb_divider_pkg::*;
#(
  parameter int DWIDTH = 8,
  parameter int CWIDTH = (DWIDTH - 1) / 4 + 1
) (
  input  logic [DWIDTH-1:0] dividendIn,
  input  logic [DWIDTH-1:0] divisorIn,
  input  logic [CWIDTH-1:0] carryIn,
  input  logic              overflowIn,
  output logic [DWIDTH-1:0] quotientOut,
  output logic [DWIDTH-1:0] remainderOut,
  output logic [CWIDTH-1:0] carryOut,
  output logic              overflowOut
);
  divStrobes_t strobes;
  logic        unusedFlags;

  // Incoming main carry and overflow take no part in the result
  assign unusedFlags = &{1'b0, overflowIn, carryIn[CWIDTH-1]};

  div_ctrl #(.DWIDTH(DWIDTH), .CWIDTH(CWIDTH)) ctrl_i (
    .divisorIn  (divisorIn),
    .carryIn    (carryIn),
    .strobes    (strobes),
    .carryOut   (carryOut),
    .overflowOut(overflowOut)
  );

  div_datapath #(.DWIDTH(DWIDTH)) dp_i (
    .dividendIn  (dividendIn),
    .divisorIn   (divisorIn),
    .strobes     (strobes),
    .quotientOut (quotientOut),
    .remainderOut(remainderOut)
  );
endmodule

// File: rtl/comb_divider_chk.sv
module comb_divider_chk #(
  parameter int DWIDTH = 8,
  parameter int CWIDTH = (DWIDTH - 1) / 4 + 1
) (
  input logic [DWIDTH-1:0] dividendIn,
  input logic [DWIDTH-1:0] divisorIn,
  input logic [CWIDTH-1:0] carryIn,
  input logic [DWIDTH-1:0] quotientOut,
  input logic [DWIDTH-1:0] remainderOut,
  input logic [CWIDTH-1:0] carryOut,
  input logic              overflowOut
);
  logic [2*DWIDTH-1:0] rebuilt;

  assign rebuilt = {{DWIDTH{1'b0}}, quotientOut} * {{DWIDTH{1'b0}}, divisorIn}
                 + {{DWIDTH{1'b0}}, remainderOut};

  always_comb begin
    if (divisorIn != '0) begin
      // R1
      quot_rebuild_chk: assert (rebuilt == {{DWIDTH{1'b0}}, dividendIn});
      // R2
      rem_bound_chk: assert (remainderOut < divisorIn);
      // R4
      no_overflow_chk: assert (!overflowOut);
    end else begin
      // R5
      zero_ovf_chk: assert (overflowOut);
      // R6
      zero_data_chk: assert (quotientOut == '1 && remainderOut == dividendIn);
    end
    // R3
    carry_clear_chk: assert (!carryOut[CWIDTH-1]);
  end

  if (CWIDTH > 1) begin : g_auxchk
    always_comb begin
      // R7
      aux_pass_chk: assert (carryOut[CWIDTH-2:0] == carryIn[CWIDTH-2:0]);
    end
  end
endmodule

bind comb_divider comb_divider_chk #(.DWIDTH(DWIDTH), .CWIDTH(CWIDTH)) chk_i (
  .dividendIn  (dividendIn),
  .divisorIn   (divisorIn),
  .carryIn     (carryIn),
  .quotientOut (quotientOut),
  .remainderOut(remainderOut),
  .carryOut    (carryOut),
  .overflowOut (overflowOut)
);

// File: tb/comb_divider_tb_top.sv
module comb_divider_tb_top;
  localparam int DWIDTH = 8;
  localparam int CWIDTH = (DWIDTH - 1) / 4 + 1;
  localparam int MAXV   = (1 << DWIDTH) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [DWIDTH-1:0] dividendIn = '0;
  logic [DWIDTH-1:0] divisorIn  = '0;
  logic [CWIDTH-1:0] carryIn    = '0;
  logic              overflowIn = 1'b0;
  logic [DWIDTH-1:0] quotientOut;
  logic [DWIDTH-1:0] remainderOut;
  logic [CWIDTH-1:0] carryOut;
  logic              overflowOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  comb_divider #(.DWIDTH(DWIDTH)) dut_i (
    .dividendIn  (dividendIn),
    .divisorIn   (divisorIn),
    .carryIn     (carryIn),
    .overflowIn  (overflowIn),
    .quotientOut (quotientOut),
    .remainderOut(remainderOut),
    .carryOut    (carryOut),
    .overflowOut (overflowOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d cin=%0d ovi=%0d)",
               req, act, exp, dividendIn, divisorIn, carryIn, overflowIn);
    end
  endtask

  // Drive one vector mid-period, let it settle (R9), compare against integer math
  task automatic applyAndCheck(input int a, input int b, input int cin, input int ovi);
    int expQ, expR, expC;
    @(negedge clk);
    dividendIn = a[DWIDTH-1:0];
    divisorIn  = b[DWIDTH-1:0];
    carryIn    = cin[CWIDTH-1:0];
    overflowIn = ovi[0];
    #1;
    expC = cin & ((1 << (CWIDTH - 1)) - 1);
    if (b != 0) begin
      expQ = a / b;
      expR = a % b;
      chk("R1 quotient", int'(quotientOut), expQ);
      chk("R2 remainder", int'(remainderOut), expR);
      chk("R4 overflow clear", int'(overflowOut), 0);
    end else begin
      chk("R5 overflow set", int'(overflowOut), 1);
      chk("R6 quotient ones", int'(quotientOut), MAXV);
      chk("R6 remainder passthru", int'(remainderOut), a);
    end
    chk("R3 R7 carry vector", int'(carryOut), expC);
  endtask

  task automatic testIdle();
    // Power-up inputs: all zero, so the divisor is zero
    #1;
    chk("R5 idle overflow", int'(overflowOut), 1);
    chk("R6 idle quotient", int'(quotientOut), MAXV);
    chk("R6 idle remainder", int'(remainderOut), 0);
    chk("R3 idle carry", int'(carryOut), 0);
  endtask

  task automatic testDirected();
    applyAndCheck(100, 7, 0, 0);
    applyAndCheck(MAXV, 1, 0, 0);
    applyAndCheck(0, 5, 0, 0);
    applyAndCheck(5, MAXV, 0, 0);
    applyAndCheck(MAXV, MAXV, 0, 0);
    applyAndCheck(7, 100, 0, 0);
    applyAndCheck(128, 2, 0, 0);
  endtask

  // Same dividend, divisor flipping between zero and nonzero (R5 R6 R9)
  task automatic testZeroToggle();
    int vals[4] = '{0, 1, 0, MAXV};
    foreach (vals[i]) applyAndCheck(200, vals[i], 0, 0);
    foreach (vals[i]) applyAndCheck(MAXV, vals[i], 3, 1);
    applyAndCheck(0, 0, 1, 0);
  endtask

  // R8: outputs identical under every incoming flag combination
  task automatic testFlagsIgnored();
    int ops[4][2] = '{'{93, 10}, '{MAXV, 0}, '{17, 17}, '{1, MAXV}};
    for (int p = 0; p < 4; p++) begin
      int refQ, refR, refV, refTop;
      refQ = -1; refR = -1; refV = -1; refTop = -1;
      for (int f = 0; f < (1 << (CWIDTH + 1)); f++) begin
        applyAndCheck(ops[p][0], ops[p][1], f & ((1 << CWIDTH) - 1), f >> CWIDTH);
        if (refQ < 0) begin
          refQ = int'(quotientOut); refR = int'(remainderOut);
          refV = int'(overflowOut); refTop = int'(carryOut[CWIDTH-1]);
        end else begin
          chk("R8 quotient stable", int'(quotientOut), refQ);
          chk("R8 remainder stable", int'(remainderOut), refR);
          chk("R8 overflow stable", int'(overflowOut), refV);
          chk("R8 carry top stable", int'(carryOut[CWIDTH-1]), refTop);
        end
      end
    end
  endtask

  task automatic testSweep();
    for (int a = 0; a <= MAXV; a++)
      for (int b = 0; b <= MAXV; b++)
        applyAndCheck(a, b, (a + b) & ((1 << CWIDTH) - 1), b & 1);
  endtask

  initial begin
    testIdle();
    testDirected();
    testZeroToggle();
    testFlagsIgnored();
    testSweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule